// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits beside an SPI shift engine and keeps its byte queues. It holds a four-byte receive queue and a four-byte transmit queue. It reports how full each queue is, catches bytes that arrive at a full receive queue and transfers that start on an empty transmit queue, and raises completion interrupts. A single transfer-mode input decides whether completion is counted on the transmit side or on the receive side.

Software sees one read-only 32-bit status word. Its event flags stay set until software reads the word. A single interrupt line is the OR of the enabled flags. A flush input on each side empties that queue in one cycle. While a flush input is held, the error event on that side does not reach the interrupt.

The shift engine pushes received bytes and pops bytes to send. The host side pushes bytes to send, pops received bytes, and pulses a read strobe when it fetches the status word.

Top module: `spi_fifo_status`

## Requirements
- R1: Each queue holds up to 4 bytes and returns them in arrival order. The head byte is shown on the pop-data output while the queue is non-empty, and that output reads 0 when the queue is empty. The transmit count (0 to 4) is at status bits 3:1 and the receive count is at bits 10:8. Bits 31:12 always read 0. A push to a full transmit queue is dropped and sets no flag, and a pop from an empty receive queue has no effect.
- R2: After reset, the status word and the interrupt output are 0.
- R3: Status bit 11 is a live flag. It is 1 while the receive count is greater than the byteThresh input, and 0 otherwise.
- R4: A receive push while the receive queue is full at the start of that cycle sets sticky bit 7. The byte is dropped and the stored bytes are kept.
- R5: A transmit pop while the transmit queue is empty sets sticky bit 4. The pop-data output reads 0 in that cycle.
- R6: With txMode = 0, an accepted receive push that brings the receive count to exactly byteThresh sets sticky bit 6. With txMode = 1, bit 6 is never set. A threshold of 0 never fires.
- R7: With txMode = 1, the unit counts accepted transmit pops. When the count reaches byteThresh, it sets sticky bit 5 and restarts the count. The count is cleared while txMode = 0 or txFlush = 1.
- R8: Sticky bit 0 is set by any completion event (bit 5 or bit 6). It is also set by an overflow or underflow event that occurs while the flush input for that side is low.
- R9: A cycle with statusRd = 1 clears bits 7, 6, 5, 4 and 0 at the next clock edge. The word shown during the read cycle still carries the flags.
- R10: If a flag's setting event and statusRd fall in the same cycle, that flag stays set.
- R11: Holding a flush input forces that queue's count to 0 at the next edge and ignores pushes and pops to that queue in that cycle. An overflow or underflow event during a flush still sets bit 7 or bit 4, but it does not set bit 0.
- R12: irq = bit6 | bit5 | (bit7 & ~rxFlush) | (bit4 & ~txFlush). It is therefore low after a read cycle in which no new event occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxPush | input | 1 | Shift engine delivers a received byte |
| rxPushData | input | 8 | Received byte |
| rxPop | input | 1 | Host removes the head received byte |
| rxPopData | output | 8 | Head of receive queue, 0 when empty |
| rxFlush | input | 1 | Empty the receive queue and mask its overflow interrupt |
| txPush | input | 1 | Host queues a byte to send |
| txPushData | input | 8 | Byte to send |
| txPop | input | 1 | Shift engine starts sending the head byte |
| txPopData | output | 8 | Head of transmit queue, 0 when empty |
| txFlush | input | 1 | Empty the transmit queue and mask its underflow interrupt |
| txMode | input | 1 | 1: completion counted on transmit, 0: on receive |
| byteThresh | input | 3 | Completion byte count and excess threshold |
| statusRd | input | 1 | Software reads the status word this cycle |
| statusWord | output | 32 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
A status read and a flag-setting event can land in the same cycle. Here that is a transmit pop on an empty queue issued together with statusRd. The bench checks that bit 4 and bit 0 survive into the next cycle, and that a later read with no event clears them. A flush and an overflowing push are also driven together. The bench checks that the flag is recorded, the summary bit stays low, and the interrupt rises only once the flush input drops.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  typedef struct packed {
    logic rxWr;
    logic rxRd;
    logic rxClr;
    logic txWr;
    logic txRd;
    logic txClr;
  } fifoStrb_t;

  localparam int FLAG_SUM  = 0;
  localparam int FLAG_UF   = 1;
  localparam int FLAG_TXD  = 2;
  localparam int FLAG_RXD  = 3;
  localparam int FLAG_OVF  = 4;
  localparam int NUM_FLAGS = 5;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wr,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rd,
  input  logic             clr,
  output logic [WIDTH-1:0] rdData,
  output logic [CNTW-1:0]  count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wr) wrPtr <= nextPtr(wrPtr);
      if (rd) rdPtr <= nextPtr(rdPtr);
      case ({wr, rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wrPtr] <= wrData;
  end

  assign rdData = (count != '0) ? mem[rdPtr] : '0;

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNTW'(DEPTH));
  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> count == '0);
endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrb_t        strb,
  input  logic [WIDTH-1:0] rxPushData,
  input  logic [WIDTH-1:0] txPushData,
  output logic [WIDTH-1:0] rxPopData,
  output logic [WIDTH-1:0] txPopData,
  output logic [CNTW-1:0]  rxCount,
  output logic [CNTW-1:0]  txCount
);
  spi_byte_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) rxQ (
    .clk(clk), .rstN(rstN), .wr(strb.rxWr), .wrData(rxPushData),
    .rd(strb.rxRd), .clr(strb.rxClr), .rdData(rxPopData), .count(rxCount));

  spi_byte_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) txQ (
    .clk(clk), .rstN(rstN), .wr(strb.txWr), .wrData(txPushData),
    .rd(strb.txRd), .clr(strb.txClr), .rdData(txPopData), .count(txCount));
endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int THRW  = 3,
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int CMPW = ((CNTW > THRW) ? CNTW : THRW) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxPush,
  input  logic                 rxPop,
  input  logic                 rxFlush,
  input  logic                 txPush,
  input  logic                 txPop,
  input  logic                 txFlush,
  input  logic                 txMode,
  input  logic [THRW-1:0]      byteThresh,
  input  logic                 statusRd,
  input  logic [CNTW-1:0]      rxCount,
  input  logic [CNTW-1:0]      txCount,
  output fifoStrb_t            strb,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 rxExcess,
  output logic                 irq
);
  logic rxFull, rxEmpty, txFull, txEmpty;
  logic evOvf, evUf, evRxDone, evTxDone, evSum;
  logic [THRW-1:0] sentCnt;
  logic [NUM_FLAGS-1:0] events;
  logic [CMPW-1:0] threshExt;

  assign rxFull  = rxCount == CNTW'(DEPTH);
  assign rxEmpty = rxCount == '0;
  assign txFull  = txCount == CNTW'(DEPTH);
  assign txEmpty = txCount == '0;
  assign threshExt = CMPW'(byteThresh);

  always_comb begin
    strb.rxClr = rxFlush;
    strb.txClr = txFlush;
    strb.rxWr  = rxPush & ~rxFlush & ~rxFull;
    strb.rxRd  = rxPop  & ~rxFlush & ~rxEmpty;
    strb.txWr  = txPush & ~txFlush & ~txFull;
    strb.txRd  = txPop  & ~txFlush & ~txEmpty;
  end

  assign evOvf    = rxPush & rxFull;
  assign evUf     = txPop & txEmpty;
  assign evRxDone = ~txMode & strb.rxWr & (CMPW'(rxCount) + 1'b1 == threshExt);
  assign evTxDone = txMode & strb.txRd & (CMPW'(sentCnt) + 1'b1 == threshExt);
  assign evSum    = evRxDone | evTxDone | (evOvf & ~rxFlush) | (evUf & ~txFlush);

  always_comb begin
    events           = '0;
    events[FLAG_SUM] = evSum;
    events[FLAG_UF]  = evUf;
    events[FLAG_TXD] = evTxDone;
    events[FLAG_RXD] = evRxDone;
    events[FLAG_OVF] = evOvf;
  end

  always_ff @(posedge clk) begin
    if (!rstN || txFlush || !txMode) sentCnt <= '0;
    else if (strb.txRd) sentCnt <= evTxDone ? '0 : sentCnt + 1'b1;
  end

  generate
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : gFlag
      always_ff @(posedge clk) begin
        if (!rstN)          flags[i] <= 1'b0;
        else if (events[i]) flags[i] <= 1'b1;
        else if (statusRd)  flags[i] <= 1'b0;
      end
    end
  endgenerate

  assign rxExcess = CMPW'(rxCount) > threshExt;
  assign irq = flags[FLAG_RXD] | flags[FLAG_TXD] |
               (flags[FLAG_OVF] & ~rxFlush) | (flags[FLAG_UF] & ~txFlush);

  assert_ovf_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxPush && rxCount == CNTW'(DEPTH) |=> flags[FLAG_OVF]);
  assert_uf_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    txPop && txCount == '0 |=> flags[FLAG_UF]);
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    statusRd && !rxPush && !txPop |=> flags == '0);
  assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    statusRd && txPop && txCount == '0 |=> flags[FLAG_UF]);
  assert_unmasked_sum_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxPush && rxCount == CNTW'(DEPTH) && !rxFlush |=> flags[FLAG_SUM]);
endmodule

// File: rtl/spi_fifo_status.sv
module spi_fifo_status
  import spi_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  parameter int THRW  = 3,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxPush,
  input  logic [WIDTH-1:0] rxPushData,
  input  logic             rxPop,
  output logic [WIDTH-1:0] rxPopData,
  input  logic             rxFlush,
  input  logic             txPush,
  input  logic [WIDTH-1:0] txPushData,
  input  logic             txPop,
  output logic [WIDTH-1:0] txPopData,
  input  logic             txFlush,
  input  logic             txMode,
  input  logic [THRW-1:0]  byteThresh,
  input  logic             statusRd,
  output logic [31:0]      statusWord,
  output logic             irq
);
  fifoStrb_t strb;
  logic [CNTW-1:0] rxCount, txCount;
  logic [NUM_FLAGS-1:0] flags;
  logic rxExcess;

  spi_fifo_ctrl #(.DEPTH(DEPTH), .THRW(THRW)) ctrl (
    .clk(clk), .rstN(rstN), .rxPush(rxPush), .rxPop(rxPop), .rxFlush(rxFlush),
    .txPush(txPush), .txPop(txPop), .txFlush(txFlush), .txMode(txMode),
    .byteThresh(byteThresh), .statusRd(statusRd), .rxCount(rxCount),
    .txCount(txCount), .strb(strb), .flags(flags), .rxExcess(rxExcess), .irq(irq));

  spi_fifo_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxPushData(rxPushData),
    .txPushData(txPushData), .rxPopData(rxPopData), .txPopData(txPopData),
    .rxCount(rxCount), .txCount(txCount));

  always_comb begin
    statusWord       = '0;
    statusWord[0]    = flags[FLAG_SUM];
    statusWord[3:1]  = 3'(txCount);
    statusWord[4]    = flags[FLAG_UF];
    statusWord[5]    = flags[FLAG_TXD];
    statusWord[6]    = flags[FLAG_RXD];
    statusWord[7]    = flags[FLAG_OVF];
    statusWord[10:8] = 3'(rxCount);
    statusWord[11]   = rxExcess;
  end

  assert_irq_quiet_after_read_R12: assert property (@(posedge clk) disable iff (!rstN)
    statusRd && !rxPush && !txPop |=> !irq);
endmodule

// File: tb/tb_spi_fifo_status.sv
module tb_spi_fifo_status;
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic rxPush = 0, rxPop = 0, rxFlush = 0, txPush = 0, txPop = 0, txFlush = 0;
  logic txMode = 0, statusRd = 0;
  logic [7:0] rxPushData = 0, txPushData = 0, rxPopData, txPopData;
  logic [2:0] byteThresh = 3'd7;
  logic [31:0] statusWord;
  logic irq;
  int total = 0, bad = 0;

  spi_fifo_status dut (
    .clk(clk), .rstN(rstN), .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop),
    .rxPopData(rxPopData), .rxFlush(rxFlush), .txPush(txPush), .txPushData(txPushData),
    .txPop(txPop), .txPopData(txPopData), .txFlush(txFlush), .txMode(txMode),
    .byteThresh(byteThresh), .statusRd(statusRd), .statusWord(statusWord), .irq(irq));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pushRx(input logic [7:0] b);
    rxPush = 1; rxPushData = b; tick(); rxPush = 0;
  endtask
  task automatic pushTx(input logic [7:0] b);
    txPush = 1; txPushData = b; tick(); txPush = 0;
  endtask
  task automatic popRx();
    rxPop = 1; tick(); rxPop = 0;
  endtask
  task automatic popTx();
    txPop = 1; tick(); txPop = 0;
  endtask
  task automatic readStatus();
    statusRd = 1; tick(); statusRd = 0;
  endtask
  task automatic flushBoth();
    rxFlush = 1; txFlush = 1; tick(); rxFlush = 0; txFlush = 0;
  endtask

  task automatic testReset();
    check("R2 status after reset", statusWord, 32'h0);
    check("R2 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic testRxOrder();
    byteThresh = 3'd7; txMode = 0;
    pushRx(8'hA1); pushRx(8'hB2); pushRx(8'hC3);
    check("R1 rx count 3", {29'b0, statusWord[10:8]}, 32'd3);
    check("R1 rx head", {24'b0, rxPopData}, 32'hA1);
    popRx();
    check("R1 rx second", {24'b0, rxPopData}, 32'hB2);
    check("R1 rx count 2", {29'b0, statusWord[10:8]}, 32'd2);
    check("R1 upper bits zero", {12'b0, statusWord[31:12]}, 32'h0);
    rxFlush = 1; rxPush = 1; rxPushData = 8'h77; tick(); rxFlush = 0; rxPush = 0;
    check("R11 rx flush empties and ignores push", {29'b0, statusWord[10:8]}, 32'd0);
    check("R1 empty rx pop data", {24'b0, rxPopData}, 32'h0);
    popRx();
    check("R1 pop on empty rx no effect", statusWord, 32'h0);
  endtask

  task automatic testTxOrder();
    pushTx(8'h11); pushTx(8'h22);
    check("R1 tx count 2", {29'b0, statusWord[3:1]}, 32'd2);
    check("R1 tx head", {24'b0, txPopData}, 32'h11);
    popTx();
    check("R1 tx second", {24'b0, txPopData}, 32'h22);
    popTx();
    check("R1 tx drained", statusWord, 32'h0);
    for (int i = 0; i < 5; i++) pushTx(8'(i + 1));
    check("R1 tx full push dropped no flag", statusWord, 32'h0000_0008);
    txFlush = 1; tick(); txFlush = 0;
    check("R11 tx flush", statusWord, 32'h0);
  endtask

  task automatic testOverflow();
    for (int i = 1; i <= 4; i++) pushRx(8'(i));
    pushRx(8'h55);
    check("R4 overflow flags", statusWord, 32'h0000_0481);
    check("R12 irq on overflow", {31'b0, irq}, 32'd1);
    for (int i = 1; i <= 4; i++) begin
      check("R4 contents kept", {24'b0, rxPopData}, 32'(i));
      popRx();
    end
    check("R9 flags before read", {24'b0, statusWord[7:0]}, 32'h81);
    readStatus();
    check("R9 read clears", statusWord, 32'h0);
    check("R12 irq low after read", {31'b0, irq}, 32'd0);
  endtask

  task automatic testUnderflow();
    txPop = 1; #1;
    check("R5 pop data zero when empty", {24'b0, txPopData}, 32'h0);
    tick(); txPop = 0;
    check("R5 underflow flags", statusWord, 32'h0000_0011);
    check("R12 irq on underflow", {31'b0, irq}, 32'd1);
    readStatus();
    check("R9 underflow cleared", statusWord, 32'h0);
  endtask

  task automatic testRxDone();
    byteThresh = 3'd2; txMode = 0;
    pushRx(8'h01);
    check("R6 not yet", {31'b0, statusWord[6]}, 32'd0);
    pushRx(8'h02);
    check("R6 rx done and R8 summary", statusWord, 32'h0000_0241);
    check("R3 excess low at threshold", {31'b0, statusWord[11]}, 32'd0);
    pushRx(8'h03);
    check("R3 excess high above threshold", {31'b0, statusWord[11]}, 32'd1);
    popRx();
    check("R3 excess drops", {31'b0, statusWord[11]}, 32'd0);
    flushBoth(); readStatus();
    check("R9 cleared after rx done", statusWord, 32'h0);
  endtask

  task automatic testTxDone();
    byteThresh = 3'd3; txMode = 1;
    pushTx(8'hA0); pushTx(8'hA1); pushTx(8'hA2);
    for (int i = 0; i < 3; i++) pushRx(8'(i));
    check("R6 no rx done in tx mode", {31'b0, statusWord[6]}, 32'd0);
    popTx(); popTx();
    check("R7 not yet after two", {31'b0, statusWord[5]}, 32'd0);
    popTx();
    check("R7 tx done and R8 summary", {24'b0, statusWord[7:0]}, 32'h21);
    flushBoth(); readStatus(); txMode = 0;
    check("R9 cleared after tx done", statusWord, 32'h0);
  endtask

  task automatic testCollision();
    statusRd = 1; txPop = 1; tick(); statusRd = 0; txPop = 0;
    check("R10 event wins over read", {24'b0, statusWord[7:0]}, 32'h11);
    readStatus();
    check("R10 later read clears", statusWord, 32'h0);
  endtask

  task automatic testFlushMask();
    byteThresh = 3'd7;
    for (int i = 0; i < 4; i++) pushRx(8'(i));
    rxFlush = 1; rxPush = 1; tick(); rxPush = 0;
    check("R11 masked overflow sets bit7 only", statusWord, 32'h0000_0080);
    check("R12 irq masked during flush", {31'b0, irq}, 32'd0);
    rxFlush = 0; #1;
    check("R12 irq after flush released", {31'b0, irq}, 32'd1);
    readStatus();
    txFlush = 1; txPop = 1; tick(); txPop = 0;
    check("R11 masked underflow", statusWord, 32'h0000_0010);
    check("R12 irq masked tx", {31'b0, irq}, 32'd0);
    txFlush = 0; readStatus();
    check("R12 irq low at end", {31'b0, irq}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rstN = 1;
    testReset();
    testRxOrder();
    testTxOrder();
    testOverflow();
    testUnderflow();
    testRxDone();
    testTxDone();
    testCollision();
    testFlushMask();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule